// File: doc/BRIEF.md
# Floating-Point Status and Exception Register

This block keeps the status state of a floating-point unit. After every completed arithmetic, conversion, square-root or compare operation the datapath presents five raw IEEE exception flags with a valid strobe. The block records them as the current exceptions and tests them against a software-set trap-enable mask. If no enabled exception occurs, the flags are merged into a sticky accrued field. If an enabled exception occurs, the block raises a one-cycle trap request and marks the fault type as an IEEE exception, leaving the accrued field as it was.

Compares also deliver a 2-bit relation code and the index of one of four condition-code fields. An unordered result sets the accrued invalid bit even when the datapath reports no flags. Whether a compare is quiet or signaling is resolved by the datapath into the invalid flag it supplies, so both kinds pass through the same masking path. Software can replace the whole writable state with a full write. A partial write leaves the condition codes and the fault type untouched. The status word read back carries a constant version field. The rounding direction held in the register is also driven out as a one-hot mode.

Top module: `fpu_status_reg`

## Requirements
- R1: While reset is high, and after it is released, every field reads zero except the version field [19:17], which holds the VERSION parameter. trap_req is 0 and round_oh is 4'b0001.
- R2: An operation (op_valid=1) whose flags hit no set bit of the trap-enable mask [27:23] writes the flags into the current field [4:0] (nv=bit4, of=3, uf=2, dz=1, nx=0). It ORs them into the accrued field [9:5] and clears the fault type [16:14], all visible one clock later. When the flags are zero, the current field reads zero.
- R3: An operation whose flags AND the mask is nonzero loads the current field with the flags and the fault type with FTT_IEEE (default 1). It leaves the accrued field and all condition codes unchanged, and drives trap_req high one clock later.
- R4: trap_req is high only in the cycle after an accepted trapping operation; with no operation it returns to 0 on the next clock.
- R5: On a non-trapping operation with cmp_valid=1, condition-code field cmp_idx takes cmp_code (0 equal, 1 less, 2 greater, 3 unordered). Field 0 is at [11:10] and fields 1 to 3 are at [33:32], [35:34] and [37:36]; the other fields are unchanged.
- R6: A non-trapping compare with code 3 sets accrued invalid (bit 9) even with all flags zero.
- R7: Rounding field [31:30] decodes on round_oh: 0 gives bit0 (nearest even), 1 gives bit1 (toward zero), 2 gives bit2 (toward +inf), 3 gives bit3 (toward -inf).
- R8: A full write (sw_wr_full) loads rounding, mask, accrued, current, fault type and all four condition codes from sw_wdata at their read positions. The version field never changes.
- R9: A partial write (sw_wr_part) loads rounding, mask, accrued and current, and leaves the fault type and all condition codes unchanged.
- R10: A software write in the same cycle as an operation takes priority: the operation is dropped and no trap is raised.
- R11: With no operation and no write, the status word holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation completed this cycle |
| op_flags | input | 5 | Raw exception flags nv, of, uf, dz, nx (bit 4 down to 0) |
| cmp_valid | input | 1 | The operation is a compare; cmp_idx and cmp_code are valid |
| cmp_idx | input | 2 | Condition-code field to write |
| cmp_code | input | 2 | Relation code: 0 equal, 1 less, 2 greater, 3 unordered |
| sw_wr_full | input | 1 | Software full write |
| sw_wr_part | input | 1 | Software partial write (condition codes and fault type kept) |
| sw_wdata | input | 38 | Software write word, same layout as status_word |
| status_word | output | 38 | Assembled status word |
| round_oh | output | 4 | One-hot rounding direction |
| trap_req | output | 1 | One-cycle trap request |
| cc0 | output | 2 | Condition code field 0 |
| cc1 | output | 2 | Condition code field 1 |
| cc2 | output | 2 | Condition code field 2 |
| cc3 | output | 2 | Condition code field 3 |

## Verification
Every stored field appears directly in status_word, so a wrong update shows at the ports on the clock edge right after the offending operation or write. Two kinds of fault stay hidden until later stimulus and are exposed on purpose. A wrongly accumulated accrued bit is caught by running a trapping operation after it. A condition code or fault type corrupted by a partial write is caught by reading both back right after that write. The trap pulse is sampled both in the cycle after the operation and in the cycle after that, so a stuck or late trap shows within two clocks.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int EXC_W    = 5;
    localparam int CC_N     = 4;
    localparam int CC_W     = 2;
    localparam int CC_IDX_W = $clog2(CC_N);
    localparam int FTT_W    = 3;
    localparam int VER_W    = 3;
    localparam int RD_W     = 2;
    localparam int RD_N     = 1 << RD_W;
    localparam int WORD_W   = 38;

    localparam int CEXC_LSB = 0;
    localparam int AEXC_LSB = 5;
    localparam int CC0_LSB  = 10;
    localparam int FTT_LSB  = 14;
    localparam int VER_LSB  = 17;
    localparam int TEM_LSB  = 23;
    localparam int RD_LSB   = 30;
    localparam int CCX_LSB  = 32;

    localparam int EXC_NV   = 4;
    localparam logic [CC_W-1:0] CC_UNORD = 2'd3;

    typedef logic [CC_N-1:0][CC_W-1:0] cc_vec_t;

    typedef struct packed {
        logic [RD_W-1:0]  rd;
        logic [EXC_W-1:0] tem;
        logic [FTT_W-1:0] ftt;
        logic [EXC_W-1:0] aexc;
        logic [EXC_W-1:0] cexc;
        cc_vec_t          cc;
        logic             trap;
    } fsr_state_t;

    function automatic int cc_lsb(input int idx);
        return (idx == 0) ? CC0_LSB : CCX_LSB + CC_W * (idx - 1);
    endfunction
endpackage

// File: rtl/fsr_exc_unit.sv
module fsr_exc_unit
    import fsr_pkg::*;
#(
    parameter logic [FTT_W-1:0] FTT_IEEE = 3'd1
) (
    input  logic [EXC_W-1:0] flags,
    input  logic [EXC_W-1:0] tem,
    input  logic [EXC_W-1:0] aexc_q,
    input  logic             unordered,
    output logic [EXC_W-1:0] cexc_n,
    output logic [EXC_W-1:0] aexc_n,
    output logic [FTT_W-1:0] ftt_n,
    output logic             trap_n
);
    logic [EXC_W-1:0] unord_mask;

    always_comb begin
        unord_mask         = '0;
        unord_mask[EXC_NV] = unordered;
        trap_n             = |(flags & tem);
        cexc_n             = flags;
        if (trap_n) begin
            aexc_n = aexc_q;
            ftt_n  = FTT_IEEE;
        end else begin
            aexc_n = aexc_q | flags | unord_mask;
            ftt_n  = '0;
        end
    end
endmodule

// File: rtl/fsr_cc_bank.sv
module fsr_cc_bank
    import fsr_pkg::*;
(
    input  cc_vec_t             cc_q,
    input  logic                wr_en,
    input  logic [CC_IDX_W-1:0] wr_idx,
    input  logic [CC_W-1:0]     wr_code,
    output cc_vec_t             cc_n
);
    for (genvar i = 0; i < CC_N; i++) begin : g_cc
        assign cc_n[i] = (wr_en && (wr_idx == CC_IDX_W'(i))) ? wr_code : cc_q[i];
    end
endmodule

// File: rtl/fsr_round_dec.sv
module fsr_round_dec
    import fsr_pkg::*;
(
    input  logic [RD_W-1:0] rd,
    output logic [RD_N-1:0] mode_oh
);
    for (genvar i = 0; i < RD_N; i++) begin : g_rd
        assign mode_oh[i] = (rd == RD_W'(i));
    end
endmodule

// File: rtl/fpu_status_reg.sv
module fpu_status_reg
    import fsr_pkg::*;
#(
    parameter logic [VER_W-1:0] VERSION  = 3'd5,
    parameter logic [FTT_W-1:0] FTT_IEEE = 3'd1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [EXC_W-1:0]    op_flags,
    input  logic                cmp_valid,
    input  logic [CC_IDX_W-1:0] cmp_idx,
    input  logic [CC_W-1:0]     cmp_code,
    input  logic                sw_wr_full,
    input  logic                sw_wr_part,
    input  logic [WORD_W-1:0]   sw_wdata,
    output logic [WORD_W-1:0]   status_word,
    output logic [RD_N-1:0]     round_oh,
    output logic                trap_req,
    output logic [CC_W-1:0]     cc0,
    output logic [CC_W-1:0]     cc1,
    output logic [CC_W-1:0]     cc2,
    output logic [CC_W-1:0]     cc3
);
    fsr_state_t state_d, state_q;

    logic [EXC_W-1:0] cexc_n, aexc_n;
    logic [FTT_W-1:0] ftt_n;
    logic             trap_n;
    cc_vec_t          cc_n;
    logic             sw_any;
    logic             unordered;

    // reserved and version bits of the write word are never stored
    logic unused_wbits;
    assign unused_wbits = ^{sw_wdata[13:12], sw_wdata[22:17], sw_wdata[29:28]};

    assign sw_any    = sw_wr_full | sw_wr_part;
    assign unordered = cmp_valid && (cmp_code == CC_UNORD);

    fsr_exc_unit #(.FTT_IEEE(FTT_IEEE)) u_exc (
        .flags     (op_flags),
        .tem       (state_q.tem),
        .aexc_q    (state_q.aexc),
        .unordered (unordered),
        .cexc_n    (cexc_n),
        .aexc_n    (aexc_n),
        .ftt_n     (ftt_n),
        .trap_n    (trap_n)
    );

    fsr_cc_bank u_cc (
        .cc_q    (state_q.cc),
        .wr_en   (cmp_valid),
        .wr_idx  (cmp_idx),
        .wr_code (cmp_code),
        .cc_n    (cc_n)
    );

    fsr_round_dec u_rd (
        .rd      (state_q.rd),
        .mode_oh (round_oh)
    );

    always_comb begin
        state_d      = state_q;
        state_d.trap = 1'b0;
        if (sw_any) begin
            state_d.rd   = sw_wdata[RD_LSB   +: RD_W];
            state_d.tem  = sw_wdata[TEM_LSB  +: EXC_W];
            state_d.aexc = sw_wdata[AEXC_LSB +: EXC_W];
            state_d.cexc = sw_wdata[CEXC_LSB +: EXC_W];
            if (sw_wr_full) begin
                state_d.ftt = sw_wdata[FTT_LSB +: FTT_W];
                for (int i = 0; i < CC_N; i++) begin
                    state_d.cc[i] = sw_wdata[cc_lsb(i) +: CC_W];
                end
            end
        end else if (op_valid) begin
            state_d.cexc = cexc_n;
            state_d.aexc = aexc_n;
            state_d.ftt  = ftt_n;
            state_d.trap = trap_n;
            if (!trap_n) begin
                state_d.cc = cc_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        status_word                         = '0;
        status_word[CEXC_LSB +: EXC_W]      = state_q.cexc;
        status_word[AEXC_LSB +: EXC_W]      = state_q.aexc;
        status_word[FTT_LSB  +: FTT_W]      = state_q.ftt;
        status_word[VER_LSB  +: VER_W]      = VERSION;
        status_word[TEM_LSB  +: EXC_W]      = state_q.tem;
        status_word[RD_LSB   +: RD_W]       = state_q.rd;
        for (int i = 0; i < CC_N; i++) begin
            status_word[cc_lsb(i) +: CC_W] = state_q.cc[i];
        end
    end

    assign trap_req = state_q.trap;
    assign cc0      = state_q.cc[0];
    assign cc1      = state_q.cc[1];
    assign cc2      = state_q.cc[2];
    assign cc3      = state_q.cc[3];

    // a trap always carries the IEEE fault type
    assert_trap_ftt_R3: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (status_word[FTT_LSB +: FTT_W] == FTT_IEEE));

    // a trap leaves the accrued field untouched
    assert_trap_aexc_R3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !sw_any) |=> (!trap_req ||
            status_word[AEXC_LSB +: EXC_W] == $past(status_word[AEXC_LSB +: EXC_W])));

    // a trap comes only from an accepted operation, never from a write
    assert_trap_source_R10: assert property (@(posedge clk) disable iff (rst)
        (!op_valid || sw_any) |=> !trap_req);

    // operations never clear accrued bits
    assert_aexc_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !sw_any) |=> ((status_word[AEXC_LSB +: EXC_W] &
            $past(status_word[AEXC_LSB +: EXC_W])) == $past(status_word[AEXC_LSB +: EXC_W])));

    // idle cycles hold the whole word
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !sw_any) |=> $stable(status_word));

    // exactly one rounding mode is active
    assert_round_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $countones(round_oh) == 1);
endmodule

// File: tb/tb_fpu_status_reg.sv
`timescale 1ns/1ps
module tb_fpu_status_reg;
    localparam logic [2:0] VER  = 3'd5;
    localparam logic [2:0] FIEE = 3'd1;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [4:0]  op_flags;
    logic        cmp_valid;
    logic [1:0]  cmp_idx;
    logic [1:0]  cmp_code;
    logic        sw_wr_full;
    logic        sw_wr_part;
    logic [37:0] sw_wdata;
    logic [37:0] status_word;
    logic [3:0]  round_oh;
    logic        trap_req;
    logic [1:0]  cc0, cc1, cc2, cc3;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // expected state
    logic [1:0] e_rd;
    logic [4:0] e_tem, e_aexc, e_cexc;
    logic [2:0] e_ftt;
    logic [1:0] e_cc [4];

    always #5 clk = ~clk;

    fpu_status_reg #(.VERSION(VER), .FTT_IEEE(FIEE)) dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_flags(op_flags),
        .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_code(cmp_code),
        .sw_wr_full(sw_wr_full), .sw_wr_part(sw_wr_part), .sw_wdata(sw_wdata),
        .status_word(status_word), .round_oh(round_oh), .trap_req(trap_req),
        .cc0(cc0), .cc1(cc1), .cc2(cc2), .cc3(cc3)
    );

    function automatic logic [37:0] exp_word();
        logic [37:0] w = '0;
        w[4:0]   = e_cexc;
        w[9:5]   = e_aexc;
        w[11:10] = e_cc[0];
        w[16:14] = e_ftt;
        w[19:17] = VER;
        w[27:23] = e_tem;
        w[31:30] = e_rd;
        w[33:32] = e_cc[1];
        w[35:34] = e_cc[2];
        w[37:36] = e_cc[3];
        return w;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req, input logic exp_trap);
        check(req, "status_word", 64'(status_word), 64'(exp_word()));
        check(req, "trap_req", 64'(trap_req), 64'(exp_trap));
        check(req, "cc ports", 64'({cc3, cc2, cc1, cc0}),
              64'({e_cc[3], e_cc[2], e_cc[1], e_cc[0]}));
        check(req, "round_oh", 64'(round_oh), 64'(4'b0001 << e_rd));
    endtask

    task automatic idle_inputs();
        op_valid = 0; op_flags = '0; cmp_valid = 0; cmp_idx = '0; cmp_code = '0;
        sw_wr_full = 0; sw_wr_part = 0; sw_wdata = '0;
    endtask

    task automatic drive_op(input logic [4:0] f, input logic cv,
                            input logic [1:0] idx, input logic [1:0] code);
        @(negedge clk);
        op_valid = 1; op_flags = f; cmp_valid = cv; cmp_idx = idx; cmp_code = code;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic drive_write(input logic full, input logic [37:0] w);
        @(negedge clk);
        sw_wr_full = full; sw_wr_part = !full; sw_wdata = w;
        @(negedge clk);
        idle_inputs();
    endtask

    // R1: reset state
    task automatic t_reset();
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        e_rd = 0; e_tem = 0; e_aexc = 0; e_cexc = 0; e_ftt = 0;
        foreach (e_cc[i]) e_cc[i] = 0;
        check_state("R1", 1'b0);
        rst = 0;
        @(negedge clk);
        check_state("R1", 1'b0);
    endtask

    // R2: non-trapping operations, then zero flags
    task automatic t_accrue();
        drive_op(5'b01001, 0, 0, 0);
        e_cexc = 5'b01001; e_aexc |= 5'b01001; e_ftt = 0;
        check_state("R2", 1'b0);
        drive_op(5'b00000, 0, 0, 0);
        e_cexc = 0;
        check_state("R2", 1'b0);
    endtask

    // R8, R7: full write, version bits ignored
    task automatic t_full_write();
        logic [37:0] w = '0;
        w[4:0] = 5'b00100; w[9:5] = 5'b00010; w[11:10] = 2'd1; w[16:14] = 3'd5;
        w[19:17] = 3'd2; w[27:23] = 5'b10000; w[31:30] = 2'd2;
        w[33:32] = 2'd2; w[35:34] = 2'd3; w[37:36] = 2'd1;
        drive_write(1, w);
        e_cexc = 5'b00100; e_aexc = 5'b00010; e_cc[0] = 1; e_ftt = 5;
        e_tem = 5'b10000; e_rd = 2; e_cc[1] = 2; e_cc[2] = 3; e_cc[3] = 1;
        check_state("R8", 1'b0);
        check("R7", "round toward +inf", 64'(round_oh), 64'(4'b0100));
    endtask

    // R3, R4: trapping compare keeps accrued and cc, pulses once
    task automatic t_trap();
        drive_op(5'b10001, 1, 1, 2'd0);
        e_cexc = 5'b10001; e_ftt = FIEE;
        check_state("R3", 1'b1);
        @(negedge clk);
        check("R4", "trap after one cycle", 64'(trap_req), 64'(0));
    endtask

    // R9: partial write keeps cc and fault type
    task automatic t_partial_write();
        logic [37:0] w = '1;
        w[4:0] = 5'b00011; w[9:5] = 5'b01000; w[27:23] = 5'b10000; w[31:30] = 2'd1;
        drive_write(0, w);
        e_cexc = 5'b00011; e_aexc = 5'b01000; e_tem = 5'b10000; e_rd = 1;
        check_state("R9", 1'b0);
        check("R9", "fault type kept", 64'(status_word[16:14]), 64'(FIEE));
    endtask

    // R5: compares to different fields
    task automatic t_compare();
        drive_op(5'b00000, 1, 2, 2'd1);
        e_cexc = 0; e_ftt = 0; e_cc[2] = 1;
        check_state("R5", 1'b0);
        drive_op(5'b00001, 1, 3, 2'd0);
        e_cexc = 5'b00001; e_aexc |= 5'b00001; e_cc[3] = 0;
        check_state("R5", 1'b0);
    endtask

    // R6: unordered compare without flags
    task automatic t_unordered();
        drive_op(5'b00000, 1, 0, 2'd3);
        e_cexc = 0; e_aexc[4] = 1; e_cc[0] = 3;
        check_state("R6", 1'b0);
    endtask

    // R10: write beats a trapping operation
    task automatic t_priority();
        logic [37:0] w = '0;
        w[27:23] = 5'b10000; w[4:0] = 5'b00010;
        @(negedge clk);
        op_valid = 1; op_flags = 5'b10000; cmp_valid = 1; cmp_idx = 1; cmp_code = 2'd3;
        sw_wr_part = 1; sw_wdata = w;
        @(negedge clk);
        idle_inputs();
        e_cexc = 5'b00010; e_aexc = 0; e_tem = 5'b10000; e_rd = 0;
        check_state("R10", 1'b0);
    endtask

    // R11: idle cycles hold
    task automatic t_idle();
        repeat (4) @(negedge clk);
        check_state("R11", 1'b0);
    endtask

    // R7: each rounding code
    task automatic t_round();
        for (int m = 0; m < 4; m++) begin
            logic [37:0] w = '0;
            w[31:30] = 2'(m);
            drive_write(0, w);
            e_rd = 2'(m); e_tem = 0; e_aexc = 0; e_cexc = 0;
            check("R7", "round_oh", 64'(round_oh), 64'(4'b0001 << m));
        end
    endtask

    initial begin
        idle_inputs();
        rst = 1;
        t_reset();
        t_accrue();
        t_full_write();
        t_trap();
        t_partial_write();
        t_compare();
        t_unordered();
        t_priority();
        t_idle();
        t_round();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #200us;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule